// File: doc/BRIEF.md
# Gated Card Clock Divider

This block derives the serial clock for a memory-card or SPI host from a reference clock. An 8-bit ratio held in a small write-port register sets the output period in whole reference cycles. A ratio of zero keeps the clock off, and the register resets to zero. The divided clock reaches one of two pins. The card pin serves the card protocol, including a card driven over SPI. The other pin is a generic SPI clock for devices that are not cards. A two-bit transfer-mode input picks the pin.

A pin produces periods only while the request input for its mode reports an active command or transfer. Every period starts with its active phase and ends with its idle phase. When a request is removed, or a new ratio is written, the change takes effect only at a period boundary, so no phase is ever shortened. A polarity input sets the idle level of the SPI pin, and through that its duty split. The card pin always rests low. A ratio of one passes the reference clock through a gate whose enable is captured on the falling reference edge.

Top module: `cardclk_gen`

## Requirements
- R1: For a ratio N from 1 to 255, the selected pin repeats with a period of exactly N reference cycles while its request is held. At N=120, 1200 cycles hold exactly 10 periods.
- R2: The ratio register resets to 0. With a ratio of 0, neither pin leaves its idle level, whatever the requests.
- R3: A period begins with floor(N/2) active cycles and then ceil(N/2) idle cycles. At N=1 the pin follows the reference clock: active while the reference is high.
- R4: Mode 2'b00 and mode 2'b11 drive the card pin, which runs only while cardReq is high. Its active level is 1 and its idle level is 0.
- R5: Mode 2'b01 drives the SPI pin, which runs only while spiReq is high. Mode 2'b10 starts no period on either pin.
- R6: The SPI pin idles at spiPol and is active at the inverse of spiPol. spiPol has no effect on the card pin.
- R7: A period that has started always completes. A new period starts at the boundary only if the request for the mode is still high. Otherwise the pin rests at idle.
- R8: A ratio written while a period runs is first used by the next period that starts.
- R9: The unselected pin stays at its idle level: 0 for the card pin, spiPol for the SPI pin.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Write strobe for the ratio register |
| wrRatio | input | 8 | Ratio value to write |
| xferMode | input | 2 | Pin select: 00/11 card, 01 SPI, 10 off |
| cardReq | input | 1 | A card command is active |
| spiReq | input | 1 | An SPI transfer to a non-card device is active |
| spiPol | input | 1 | Idle level of the SPI pin |
| cardClk | output | 1 | Card-protocol clock pin |
| spiClk | output | 1 | Generic SPI clock pin |

## Verification
Even ratios (4, 6, 8), odd ratios (5, 7) and the extremes 0, 1 and 120 are run against a behavioural model that is compared on every reference cycle. The even and odd ratios separate a correct floor/ceil split from an off-by-one in either phase. Ratio 1 exercises the pass-through gate, and 120 confirms a full count over 1200 cycles. Each mode is run with both requests high, which shows that routing follows the mode and not the request. The SPI ratio is run under both polarities. Requests are dropped and the ratio is rewritten in the middle of a period, which separates boundary-aligned updates from immediate ones.

// File: rtl/cardclk_pkg.sv
`timescale 1ns/1ps
package cardclk_pkg;
  typedef enum logic [1:0] {
    MODE_CARD     = 2'b00,
    MODE_SPI      = 2'b01,
    MODE_OFF      = 2'b10,
    MODE_CARD_SPI = 2'b11
  } xferMode_e;

  // Boundary strobes from control to datapath
  typedef struct packed {
    logic load;  // start a fresh period with the staged ratio
    logic halt;  // boundary reached, no further period
  } periodStrobe_t;
endpackage

// File: rtl/cardclk_ctrl.sv
`timescale 1ns/1ps
module cardclk_ctrl
  import cardclk_pkg::*;
#(
  parameter int RATIO_W = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrEn,
  input  logic [RATIO_W-1:0] wrRatio,
  input  logic [1:0]         xferMode,
  input  logic               cardReq,
  input  logic               spiReq,
  input  logic               lastTick,
  output periodStrobe_t      strobe,
  output logic [RATIO_W-1:0] nextRatio,
  output logic               nextSpi,
  output logic               running
);
  logic [RATIO_W-1:0] regRatio;
  logic reqSel, boundary, go;

  always_comb begin
    unique case (xferMode_e'(xferMode))
      MODE_CARD, MODE_CARD_SPI: reqSel = cardReq;
      MODE_SPI:                 reqSel = spiReq;
      default:                  reqSel = 1'b0;
    endcase
  end

  assign boundary    = !running || lastTick;
  assign go          = reqSel && (regRatio != '0);
  assign strobe.load = boundary && go;
  assign strobe.halt = boundary && !go;
  assign nextRatio   = regRatio;
  assign nextSpi     = (xferMode == MODE_SPI);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      running  <= 1'b0;
      regRatio <= '0;
    end else begin
      if (boundary) running <= go;
      if (wrEn) regRatio <= wrRatio;
    end
  end
endmodule

// File: rtl/cardclk_datapath.sv
`timescale 1ns/1ps
module cardclk_datapath
  import cardclk_pkg::*;
#(
  parameter int RATIO_W = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  periodStrobe_t      strobe,
  input  logic [RATIO_W-1:0] nextRatio,
  input  logic               nextSpi,
  output logic               lastTick,
  output logic               phaseAct,
  output logic               selSpi
);
  localparam logic [RATIO_W-1:0] ONE = RATIO_W'(1);

  logic [RATIO_W-1:0] cnt, curRatio, cntInc, curHalf, nextHalf;
  logic phaseReg, bypassReg, gateEn;

  assign cntInc   = cnt + ONE;
  assign curHalf  = curRatio >> 1;
  assign nextHalf = nextRatio >> 1;
  assign lastTick = (cnt == curRatio - ONE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt       <= '0;
      curRatio  <= '0;
      selSpi    <= 1'b0;
      phaseReg  <= 1'b0;
      bypassReg <= 1'b0;
    end else if (strobe.load) begin
      cnt       <= '0;
      curRatio  <= nextRatio;
      selSpi    <= nextSpi;
      phaseReg  <= (nextHalf != '0);
      bypassReg <= (nextRatio == ONE);
    end else if (strobe.halt) begin
      cnt       <= '0;
      phaseReg  <= 1'b0;
      bypassReg <= 1'b0;
    end else begin
      cnt      <= cntInc;
      phaseReg <= (cntInc < curHalf);
    end
  end

  // Pass-through enable changes only while the reference is low
  always_ff @(negedge clk or negedge rstN) begin
    if (!rstN) gateEn <= 1'b0;
    else       gateEn <= bypassReg;
  end

  assign phaseAct = phaseReg | (clk & gateEn);
endmodule

// File: rtl/cardclk_gen.sv
`timescale 1ns/1ps
module cardclk_gen
  import cardclk_pkg::*;
#(
  parameter int RATIO_W = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrEn,
  input  logic [RATIO_W-1:0] wrRatio,
  input  logic [1:0]         xferMode,
  input  logic               cardReq,
  input  logic               spiReq,
  input  logic               spiPol,
  output logic               cardClk,
  output logic               spiClk
);
  periodStrobe_t      strobe;
  logic [RATIO_W-1:0] nextRatio;
  logic nextSpi, running, lastTick, phaseAct, selSpi;

  cardclk_ctrl #(.RATIO_W(RATIO_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrRatio(wrRatio),
    .xferMode(xferMode), .cardReq(cardReq), .spiReq(spiReq),
    .lastTick(lastTick), .strobe(strobe), .nextRatio(nextRatio),
    .nextSpi(nextSpi), .running(running)
  );

  cardclk_datapath #(.RATIO_W(RATIO_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .nextRatio(nextRatio),
    .nextSpi(nextSpi), .lastTick(lastTick), .phaseAct(phaseAct),
    .selSpi(selSpi)
  );

  assign cardClk = !selSpi && phaseAct;
  assign spiClk  = spiPol ^ (selSpi && phaseAct);
endmodule

// File: rtl/cardclk_chk.sv
`timescale 1ns/1ps
module cardclk_chk (
  input logic       clk,
  input logic       rstN,
  input logic       wrEn,
  input logic [1:0] xferMode,
  input logic       spiPol,
  input logic       cardClk,
  input logic       spiClk,
  input logic       running,
  input logic       lastTick,
  input logic       phaseAct
);
  // R9: never both pins away from idle
  assert_pins_exclusive_R9: assert property (@(posedge clk) disable iff (!rstN)
    !(cardClk && (spiClk != spiPol)));

  // R7: no active phase without a running period
  assert_idle_when_stopped_R7: assert property (@(posedge clk) disable iff (!rstN)
    !running |-> !phaseAct);

  // R5: off mode never starts a period
  assert_off_mode_R5: assert property (@(posedge clk) disable iff (!rstN)
    (xferMode == 2'b10) && !running |=> !running);

  // R8: a ratio write inside a period never ends it early
  assert_write_keeps_period_R8: assert property (@(posedge clk) disable iff (!rstN)
    wrEn && running && !lastTick |=> running);

  // R6: polarity flip alone moves the SPI pin only when stopped
  assert_pol_idle_R6: assert property (@(posedge clk) disable iff (!rstN)
    !running && !$past(running) |-> (spiClk == spiPol) && !cardClk);
endmodule

bind cardclk_gen cardclk_chk u_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .xferMode(xferMode),
  .spiPol(spiPol), .cardClk(cardClk), .spiClk(spiClk),
  .running(running), .lastTick(lastTick), .phaseAct(phaseAct)
);

// File: tb/test_cardclk_gen.sv
`timescale 1ns/1ps
module test_cardclk_gen;
  logic clk = 1'b0, rstN = 1'b0, wrEn = 1'b0;
  logic [7:0] wrRatio = '0;
  logic [1:0] xferMode = 2'b00;
  logic cardReq = 1'b0, spiReq = 1'b0, spiPol = 1'b0;
  logic cardClk, spiClk;

  int nRun = 0, nFail = 0;
  bit done = 0;
  string tag = "R2";

  // behavioural model state
  bit mRun = 0, mSpi = 0, mGate = 0;
  int mCnt = 0, mRatio = 0, mReg = 0;

  cardclk_gen i_cardclk_gen (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrRatio(wrRatio),
    .xferMode(xferMode), .cardReq(cardReq), .spiReq(spiReq),
    .spiPol(spiPol), .cardClk(cardClk), .spiClk(spiClk)
  );

  always #2.5 clk = ~clk;

  task automatic check(string t, logic act, logic exp, string what);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s: got %0b expected %0b at %0t", t, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) mGate = mRun && (mRatio == 1);

  always @(posedge clk) begin
    bit req, act;
    if (!rstN) begin
      mRun = 0; mCnt = 0; mRatio = 0; mReg = 0; mSpi = 0;
    end else begin
      case (xferMode)
        2'b00, 2'b11: req = cardReq;
        2'b01:        req = spiReq;
        default:      req = 0;
      endcase
      if (!mRun || mCnt == mRatio - 1) begin
        if (req && mReg != 0) begin
          mRun = 1; mCnt = 0; mRatio = mReg; mSpi = (xferMode == 2'b01);
        end else begin
          mRun = 0; mCnt = 0;
        end
      end else mCnt++;
      if (wrEn) mReg = wrRatio;
    end
    #1;
    if (rstN && !done) begin
      act = (mRun && mCnt < mRatio / 2) || mGate;
      check(tag, cardClk, !mSpi && act, "cardClk");
      check(tag, spiClk, spiPol ^ (mSpi && act), "spiClk");
    end
  end

  task automatic writeRatio(int r);
    @(negedge clk); wrEn = 1; wrRatio = 8'(r);
    @(negedge clk); wrEn = 0;
  endtask

  task automatic waitCyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 150000);
    nFail++;
    $display("FAIL watchdog: got timeout expected completion");
    finishRun();
  end

  initial begin
    int highs, edges;
    logic prev;
    waitCyc(3);
    #1;
    check("R2", cardClk, 1'b0, "reset cardClk");
    check("R2", spiClk, 1'b0, "reset spiClk");
    rstN = 1;
    // R2: zero ratio keeps pins idle despite requests
    tag = "R2";
    @(negedge clk); cardReq = 1; spiReq = 1;
    waitCyc(20);
    // R1 R4: even ratio on card pin, spiReq high too (R9)
    tag = "R1";
    writeRatio(6); waitCyc(60);
    // R3: odd ratio duty count
    tag = "R3";
    @(negedge clk); cardReq = 0; waitCyc(12);
    writeRatio(5);
    @(negedge clk); cardReq = 1;
    highs = 0;
    repeat (50) begin @(posedge clk); #1; if (cardClk) highs++; end
    check("R3", highs == 20, 1'b1, "ratio 5 active count");
    // R3: ratio 1 pass-through
    writeRatio(1); waitCyc(30);
    // R1: ratio 120 gives 10 periods in 1200 cycles
    tag = "R1";
    @(negedge clk); cardReq = 0; waitCyc(8);
    writeRatio(120);
    @(negedge clk); cardReq = 1;
    edges = 0; prev = 1'b0;
    repeat (1200) begin
      @(posedge clk); #1;
      if (cardClk && !prev) edges++;
      prev = cardClk;
    end
    check("R1", edges == 10, 1'b1, "ratio 120 period count");
    // R4: mode 11 uses card pin
    tag = "R4";
    @(negedge clk); cardReq = 0; waitCyc(130);
    writeRatio(4);
    @(negedge clk); xferMode = 2'b11; cardReq = 1; spiReq = 1;
    waitCyc(40);
    // R5 R9: SPI mode with cardReq held high
    tag = "R5";
    @(negedge clk); cardReq = 0; waitCyc(6);
    writeRatio(7);
    @(negedge clk); xferMode = 2'b01; cardReq = 1;
    waitCyc(50);
    // R6: inverted polarity
    tag = "R6";
    @(negedge clk); spiReq = 0; waitCyc(10);
    @(negedge clk); spiPol = 1; spiReq = 1;
    waitCyc(50);
    // R5: off mode
    tag = "R5";
    @(negedge clk); spiReq = 0; waitCyc(10);
    @(negedge clk); xferMode = 2'b10; spiReq = 1; cardReq = 1;
    waitCyc(30);
    // R7: request drop mid period
    tag = "R7";
    writeRatio(8);
    @(negedge clk); xferMode = 2'b00; spiPol = 0;
    waitCyc(11);
    @(negedge clk); cardReq = 0;
    waitCyc(20);
    // R8: ratio rewritten mid period
    tag = "R8";
    writeRatio(4);
    @(negedge clk); cardReq = 1;
    waitCyc(1);
    writeRatio(9);
    waitCyc(40);
    finishRun();
  end
endmodule